// File: doc/BRIEF.md
# Flow-Through Burst SRAM Without Turnaround Cycles

This block is a synchronous single-port memory of 18-bit words: 16 data bits plus 2 parity bits. A read presents its word in the clock cycle right after the edge that took the address, and nothing else delays it. A write takes its address on one edge and its data on the following qualified edge. Because of this, reads and writes can follow each other on every cycle with no idle slot between them. It can serve as an on-chip scratchpad or as a behavioural model of an external burst memory.

One address starts an access. Up to three further accesses can follow by asserting `advance`, which steps a two-bit offset inside the aligned group of four words. The step order is either interleaved or linear. A clock enable freezes the whole pipeline. Three chip selects gate new accesses. The data bus is split into `din`, `dout` and a drive enable `dout_en`, so a pad ring or a bus multiplexer can build the shared data lines from them.

Top module: `ftburst_sram`

## Requirements
- R1: While `rst` is high (synchronous, active high), and after it until the first selected load, the device is deselected and `dout_en` is 0.
- R2: With `cke_n` high at a rising edge, nothing changes: the pending write data is not taken, the burst offset does not move, and `dout`/`dout_en` keep their values.
- R3: A load edge is an edge with `cke_n` low and `advance` low. It selects the device only when `ce_a_n`=0, `ce_b`=1 and `ce_c_n`=0. Any other combination deselects the device, and `dout_en` is 0 in the following cycle.
- R4: A selected load with `wr_n`=1 is a read. The word at `addr` appears on `dout` in the cycle after that edge.
- R5: A selected load with `wr_n`=0 is a write. The next qualified edge captures `din` and `lane_n`, and that edge may itself start a new read, write or deselect.
- R6: `lane_n` is active low. `lane_n[0]` enables bits 7:0 and bit 16. `lane_n[1]` enables bits 15:8 and bit 17. Lanes that are not enabled keep their contents, and `lane_n`=2'b11 writes nothing.
- R7: With `order_il`=1, each qualified edge with `advance` high moves the access to offset (start XOR count) in address bits 1:0. The count runs 1, 2, 3, then wraps to 0, and the upper address bits stay fixed.
- R8: With `order_il`=0, the offset is (start + count) mod 4.
- R9: On an advance edge the chip selects and `wr_n` are ignored. The burst keeps the read or write type of its load.
- R10: `dout_en` is 0 in a write data cycle and in the first cycle after a selected load that follows a deselected state, whatever the level of `oe_n`.
- R11: In all other read cycles, `dout_en` follows `oe_n` (low drives) without waiting for a clock.
- R12: A read issued on the same edge that completes a write to the same address returns the written lanes merged with the old unwritten lanes.
- R13: An advance edge while the device is deselected leaves it deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cke_n | input | 1 | Clock qualifier, active low |
| ce_a_n | input | 1 | Chip select, active low |
| ce_b | input | 1 | Chip select, active high |
| ce_c_n | input | 1 | Chip select, active low |
| advance | input | 1 | 1 steps the burst, 0 loads a new address |
| wr_n | input | 1 | Write request at a load, active low |
| lane_n | input | 2 | Lane write enables, active low |
| addr | input | AW | Word address |
| order_il | input | 1 | Burst order: 1 interleaved, 0 linear |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | 18 | Write data, parity in bits 17:16 |
| dout | output | 18 | Read data |
| dout_en | output | 1 | Drive enable for the data lines |

## Verification
A wrong burst offset or a lost access type shows up in the very next cycle as a wrong word on `dout`, or as `dout_en` rising during a write burst. A pending write that is lost or taken twice during a clock-enable stall stays hidden until that address is read back, so every stalled write is followed at once by a read of the same address. A forwarding fault appears only when a read hits the word being completed on the same edge, and a missing deselect flag appears only on the first cycle after the device comes out of deselect. The reference model therefore compares the data on every enabled cycle and the drive enable on every cycle.

// File: rtl/ftb_pkg.sv
package ftb_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 2;
  localparam int DATA_W = LANES * BYTE_W;
  localparam int WORD_W = DATA_W + LANES;
  localparam int LANE_W = BYTE_W + 1;

  // offset inside the aligned group of four for a given burst count
  function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                             input logic [1:0] count,
                                             input logic interleave);
    return interleave ? (start ^ count) : (start + count);
  endfunction

  // lane k = parity bit k on top of data byte k
  function automatic logic [LANE_W-1:0] lane_get(input logic [WORD_W-1:0] w,
                                                 input int k);
    return {w[DATA_W+k], w[k*BYTE_W +: BYTE_W]};
  endfunction
endpackage

// File: rtl/ftb_ctrl.sv
module ftb_ctrl
  import ftb_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          qual,
  input  logic          advance,
  input  logic          sel_ok,
  input  logic          wr_n,
  input  logic          interleave,
  input  logic [AW-1:0] addr,
  output logic          acc_valid,
  output logic          acc_wr,
  output logic          acc_first,
  output logic [AW-1:0] acc_addr,
  output logic          nxt_valid,
  output logic          nxt_wr,
  output logic [AW-1:0] nxt_addr
);
  logic [AW-1:0] base_q, nbase;
  logic [1:0]    cnt_q, ncnt;

  // decode of the access that the coming qualified edge starts
  always_comb begin
    nxt_valid = acc_valid;
    nxt_wr    = acc_wr;
    nbase     = base_q;
    ncnt      = cnt_q;
    if (!advance) begin
      nxt_valid = sel_ok;
      nxt_wr    = sel_ok & ~wr_n;
      nbase     = addr;
      ncnt      = '0;
    end else if (acc_valid) begin
      ncnt = cnt_q + 2'd1;
    end
    nxt_addr = {nbase[AW-1:2], beat_offset(nbase[1:0], ncnt, interleave)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_valid <= 1'b0;
      acc_wr    <= 1'b0;
      acc_first <= 1'b0;
      base_q    <= '0;
      cnt_q     <= '0;
      acc_addr  <= '0;
    end else if (qual) begin
      acc_valid <= nxt_valid;
      acc_wr    <= nxt_wr;
      acc_first <= nxt_valid & ~acc_valid;
      base_q    <= nbase;
      cnt_q     <= ncnt;
      acc_addr  <= nxt_addr;
    end
  end
endmodule

// File: rtl/ftb_store.sv
module ftb_store
  import ftb_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [LANES-1:0]  lane_off_n,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q, fwd_d;
    logic              fwd_q, lane_we;

    assign lane_we = wr_en & ~lane_off_n[k];

    // one read port, one write port: block RAM friendly
    always_ff @(posedge clk) begin
      if (lane_we) mem[wr_addr] <= lane_get(wdata, k);
      if (rd_en)   rd_q <= mem[rd_addr];
    end

    // bypass when the read hits the word being completed on this edge
    always_ff @(posedge clk) begin
      if (rst)        fwd_q <= 1'b0;
      else if (rd_en) fwd_q <= lane_we && (wr_addr == rd_addr);
    end

    always_ff @(posedge clk) begin
      if (rd_en) fwd_d <= lane_get(wdata, k);
    end

    assign rdata[k*BYTE_W +: BYTE_W] = fwd_q ? fwd_d[BYTE_W-1:0] : rd_q[BYTE_W-1:0];
    assign rdata[DATA_W+k]           = fwd_q ? fwd_d[BYTE_W]     : rd_q[BYTE_W];
  end
endmodule

// File: rtl/ftburst_sram.sv
module ftburst_sram
  import ftb_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke_n,
  input  logic              ce_a_n,
  input  logic              ce_b,
  input  logic              ce_c_n,
  input  logic              advance,
  input  logic              wr_n,
  input  logic [LANES-1:0]  lane_n,
  input  logic [AW-1:0]     addr,
  input  logic              order_il,
  input  logic              oe_n,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout,
  output logic              dout_en
);
  logic          qual, sel_ok;
  logic          acc_valid, acc_wr, acc_first;
  logic          nxt_valid, nxt_wr;
  logic [AW-1:0] acc_addr, nxt_addr;
  logic          wr_en, rd_en;

  assign qual   = ~cke_n;
  assign sel_ok = ~ce_a_n & ce_b & ~ce_c_n;

  ftb_ctrl #(.AW(AW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .qual      (qual),
    .advance   (advance),
    .sel_ok    (sel_ok),
    .wr_n      (wr_n),
    .interleave(order_il),
    .addr      (addr),
    .acc_valid (acc_valid),
    .acc_wr    (acc_wr),
    .acc_first (acc_first),
    .acc_addr  (acc_addr),
    .nxt_valid (nxt_valid),
    .nxt_wr    (nxt_wr),
    .nxt_addr  (nxt_addr)
  );

  // the write in flight completes on the next qualified edge
  assign wr_en = qual & acc_valid & acc_wr;
  assign rd_en = qual & nxt_valid & ~nxt_wr;

  ftb_store #(.AW(AW)) u_store (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .lane_off_n(lane_n),
    .wr_addr   (acc_addr),
    .wdata     (din),
    .rd_en     (rd_en),
    .rd_addr   (nxt_addr),
    .rdata     (dout)
  );

  assign dout_en = acc_valid & ~acc_wr & ~acc_first & ~oe_n;
endmodule

// File: rtl/ftb_chk.sv
module ftb_chk (
  input logic        clk,
  input logic        rst,
  input logic        cke_n,
  input logic        ce_a_n,
  input logic        ce_b,
  input logic        ce_c_n,
  input logic        advance,
  input logic        wr_n,
  input logic        oe_n,
  input logic [17:0] dout,
  input logic        dout_en,
  input logic        acc_valid
);
  logic sel;
  assign sel = !ce_a_n && ce_b && !ce_c_n;

  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !dout_en);

  p_stall_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (cke_n && dout_en) |=> $stable(dout));

  p_deselect_off_r3: assert property (@(posedge clk) disable iff (rst)
    (!cke_n && !advance && !sel) |=> !dout_en);

  p_write_hiz_r10: assert property (@(posedge clk) disable iff (rst)
    (!cke_n && !advance && sel && !wr_n) |=> !dout_en);

  p_emerge_hiz_r10: assert property (@(posedge clk) disable iff (rst)
    (!cke_n && !advance && sel && !acc_valid) |=> !dout_en);

  p_oe_gate_r11: assert property (@(posedge clk) disable iff (rst)
    dout_en |-> !oe_n);

  p_idle_advance_r13: assert property (@(posedge clk) disable iff (rst)
    (!cke_n && advance && !acc_valid) |=> !dout_en);
endmodule

bind ftburst_sram ftb_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .cke_n    (cke_n),
  .ce_a_n   (ce_a_n),
  .ce_b     (ce_b),
  .ce_c_n   (ce_c_n),
  .advance  (advance),
  .wr_n     (wr_n),
  .oe_n     (oe_n),
  .dout     (dout),
  .dout_en  (dout_en),
  .acc_valid(acc_valid)
);

// File: tb/ftburst_sram_bench.sv
module ftburst_sram_bench;
  localparam int AW = 10;
  localparam logic [2:0] SEL  = 3'b010;
  localparam logic [2:0] OFF1 = 3'b110;
  localparam logic [2:0] OFF2 = 3'b000;
  localparam logic [2:0] OFF3 = 3'b011;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          cke_n = 1'b1, advance = 1'b0, wr_n = 1'b1;
  logic          ce_a_n = 1'b1, ce_b = 1'b0, ce_c_n = 1'b1;
  logic          order_il = 1'b1, oe_n = 1'b0;
  logic [1:0]    lane_n = 2'b11;
  logic [AW-1:0] addr = '0;
  logic [17:0]   din = '0;
  logic [17:0]   dout;
  logic          dout_en;

  int total = 0;
  int bad   = 0;

  // behavioural reference
  logic [17:0] mm [1<<AW];
  bit          m_v = 0, m_w = 0, m_first = 0;
  int          m_base = 0, m_cnt = 0, m_a = 0;
  logic [17:0] m_q = '0;

  ftburst_sram #(.AW(AW)) u_ftburst_sram (
    .clk(clk), .rst(rst), .cke_n(cke_n), .ce_a_n(ce_a_n), .ce_b(ce_b),
    .ce_c_n(ce_c_n), .advance(advance), .wr_n(wr_n), .lane_n(lane_n),
    .addr(addr), .order_il(order_il), .oe_n(oe_n), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  task automatic chk(input string tag, input string what,
                     input logic [17:0] act, input logic [17:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input string tag, input logic cen, input logic adv,
                     input logic [2:0] ce, input logic wn, input int a,
                     input logic [1:0] bs, input logic [17:0] d);
    bit nv, nw;
    int off;
    logic exp_en;
    @(negedge clk);
    cke_n = cen; advance = adv; {ce_a_n, ce_b, ce_c_n} = ce;
    wr_n = wn; addr = a[AW-1:0]; lane_n = bs; din = d;
    @(posedge clk);
    if (!cen) begin
      if (m_v && m_w) begin
        if (!bs[0]) begin mm[m_a][7:0]  = d[7:0];  mm[m_a][16] = d[16]; end
        if (!bs[1]) begin mm[m_a][15:8] = d[15:8]; mm[m_a][17] = d[17]; end
      end
      nv = m_v; nw = m_w;
      if (!adv) begin
        nv = (ce == SEL);
        nw = nv && !wn;
        if (nv) begin m_base = a; m_cnt = 0; end
      end else if (m_v) begin
        m_cnt = (m_cnt + 1) % 4;
      end
      off = order_il ? ((m_base % 4) ^ m_cnt) : (((m_base % 4) + m_cnt) % 4);
      m_first = nv && !m_v;
      m_v = nv; m_w = nw;
      m_a = (m_base / 4) * 4 + off;
      if (nv && !nw) m_q = mm[m_a];
    end
    #2;
    exp_en = m_v && !m_w && !m_first && !oe_n;
    chk(tag, "dout_en", {17'd0, dout_en}, {17'd0, exp_en});
    if (exp_en) chk(tag, "dout", dout, m_q);
  endtask

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) mm[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1", "dout_en after reset", {17'd0, dout_en}, 18'd0);

    cyc("R3", 0, 0, OFF1, 1, 5, 2'b11, 0);
    // back-to-back write, write, read, read
    cyc("R5", 0, 0, SEL, 0, 5, 2'b11, 0);
    cyc("R5", 0, 0, SEL, 0, 6, 2'b00, 18'h2A5A5);
    cyc("R5", 0, 0, SEL, 1, 5, 2'b00, 18'h15A5A);
    cyc("R4", 0, 0, SEL, 1, 6, 2'b11, 0);
    cyc("R5", 0, 0, SEL, 0, 7, 2'b11, 0);
    // lane writes and same-edge forwarding
    cyc("R6", 0, 0, SEL, 0, 7, 2'b00, 18'h3C3C3);
    cyc("R12", 0, 0, SEL, 1, 7, 2'b10, 18'h01234);
    cyc("R12", 0, 0, SEL, 0, 7, 2'b11, 0);
    cyc("R6", 0, 0, SEL, 1, 7, 2'b11, 18'h0FFFF);
    cyc("R6", 0, 0, SEL, 1, 7, 2'b11, 0);
    // stall while a write waits for its data
    cyc("R2", 0, 0, SEL, 0, 9, 2'b11, 0);
    cyc("R2", 1, 0, OFF2, 1, 3, 2'b00, 18'h11111);
    cyc("R2", 1, 1, SEL, 0, 4, 2'b00, 18'h22222);
    cyc("R2", 0, 0, SEL, 1, 9, 2'b00, 18'h2468A);
    cyc("R3", 0, 0, OFF2, 1, 0, 2'b11, 0);
    // interleaved write burst from offset 2
    order_il = 1'b1;
    cyc("R7", 0, 0, SEL, 0, 'h12, 2'b11, 0);
    cyc("R7", 0, 1, SEL, 1, 0, 2'b00, 18'h10012);
    cyc("R9", 0, 1, OFF2, 1, 0, 2'b00, 18'h10013);
    cyc("R7", 0, 1, SEL, 0, 0, 2'b00, 18'h10010);
    cyc("R7", 0, 0, SEL, 1, 'h12, 2'b00, 18'h10011);
    // interleaved read burst with a stall and ignored controls, wrapping
    cyc("R9", 0, 1, SEL, 0, 0, 2'b11, 0);
    cyc("R2", 1, 1, SEL, 1, 0, 2'b11, 0);
    cyc("R9", 0, 1, OFF1, 1, 0, 2'b11, 0);
    cyc("R7", 0, 1, SEL, 1, 0, 2'b11, 0);
    cyc("R7", 0, 1, SEL, 1, 0, 2'b11, 0);
    cyc("R7", 0, 0, SEL, 1, 'h13, 2'b11, 0);
    // linear read burst from offset 3, wrapping
    order_il = 1'b0;
    cyc("R8", 0, 1, SEL, 1, 0, 2'b11, 0);
    cyc("R8", 0, 1, SEL, 1, 0, 2'b11, 0);
    cyc("R8", 0, 1, SEL, 1, 0, 2'b11, 0);
    cyc("R8", 0, 1, SEL, 1, 0, 2'b11, 0);
    cyc("R8", 0, 0, SEL, 0, 'h21, 2'b11, 0);
    // linear write burst then read back
    cyc("R8", 0, 1, SEL, 1, 0, 2'b00, 18'h0AB21);
    cyc("R8", 0, 0, SEL, 1, 'h21, 2'b00, 18'h0AB22);
    cyc("R8", 0, 1, SEL, 1, 0, 2'b11, 0);
    cyc("R3", 0, 0, OFF3, 1, 0, 2'b11, 0);
    // deselected behaviour and output enable
    cyc("R13", 0, 1, SEL, 1, 0, 2'b11, 0);
    cyc("R10", 0, 0, SEL, 1, 5, 2'b11, 0);
    cyc("R4", 0, 0, SEL, 1, 6, 2'b11, 0);
    #1 oe_n = 1'b1;
    #1 chk("R11", "dout_en with oe_n high", {17'd0, dout_en}, 18'd0);
    cyc("R11", 0, 0, SEL, 1, 5, 2'b11, 0);
    oe_n = 1'b0;
    cyc("R11", 0, 0, OFF1, 1, 0, 2'b11, 0);
    cyc("R3", 0, 0, OFF1, 1, 0, 2'b11, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule